// File: doc/BRIEF.md
# Palettized LCD Pixel Unpacker

The block takes 64-bit display words from an upstream word buffer and turns them into a stream of single pixel colours for the panel side. A word is held until every pixel in it has been handed out. Each pixel is then either looked up in a 256-entry, 16-bit colour table (1, 2, 4 and 8 bits per pixel) or passed through unchanged as true colour (16 and 24 bits per pixel). Both sides use a ready/valid handshake.

Three orderings of pixels inside a word can be selected: least significant bits first, most significant bits first, and a mixed order. In the mixed order bytes are walked from least to most significant, but inside each byte the pixels run from the top bits down. The colour table is filled through a write-only port of 32 bits, and each write carries two table entries.

Top module: `lcd_pixel_unpack`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after it is released, pix_valid is 0 and in_ready is 1.
- R2: For depth code 0/1/2/3 (1/2/4/8 bits per pixel), each pixel value is a colour-table index, and pix_data is {8'h00, entry[index]}.
- R3: A write to table word A with pal_we high stores entry 2A from bits 15:0 and entry 2A+1 from bits 31:16. The output shows new contents from the cycle after the write, even while a pixel is being held.
- R4: Depth code 4 (16 bits per pixel) bypasses the table, and pix_data is {8'h00, pixel}. Each word holds 4 pixels.
- R5: Depth codes 5, 6 and 7 (24 bits per pixel) use 32-bit slots, 2 per word. pix_data is the low 24 bits of the slot.
- R6: For order code 0 or 3 (little-endian), pixel k of a word is taken from bits starting at k times the pixel width.
- R7: For order code 1 (big-endian), pixel k is taken from the top of the word down, starting at bit 64 minus (k+1) times the width.
- R8: For order code 2 (mixed) at widths below 8, bytes are taken lowest first, and inside each byte pixels run from the most significant bits down. At widths of 8 or more, order code 2 behaves like order code 0.
- R9: A word yields 64 divided by the slot width in pixels. in_ready is high while a word is held only when its last pixel is on the output with pix_ready high, so the next word can be taken in that same cycle.
- R10: While pix_valid is high and pix_ready is low, the pixel and pix_valid stay unchanged and no new word is taken.
- R11: When nothing is held, in_ready is 1. A word accepted in one cycle gives pix_valid high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bpp_sel | input | 3 | Depth code: 0=1, 1=2, 2=4, 3=8, 4=16, 5..7=24 bits per pixel |
| order_sel | input | 2 | Order code: 0/3 little-endian, 1 big-endian, 2 mixed |
| in_data | input | 64 | Display word from the buffer |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Unpacker takes in_data this cycle |
| pal_we | input | 1 | Colour-table write strobe |
| pal_addr | input | 7 | Colour-table word address |
| pal_wdata | input | 32 | Two entries: odd entry in 31:16, even entry in 15:0 |
| pix_data | output | 24 | Pixel colour |
| pix_valid | output | 1 | pix_data is valid |
| pix_ready | input | 1 | Panel side takes the pixel |

## Verification
The assertions check the handshake rules on every cycle. A stalled pixel keeps pix_valid and holds its value unless the table or the mode inputs change. No word is taken during a stall. An empty unpacker is always ready, and an accepted word always shows up as valid in the next cycle. They also check that the top byte stays zero in every mode below 24 bits. The bench scenarios are needed to show the actual pixel values and their order for each depth and byte order, the table's even/odd split, a table rewrite taking effect while a pixel is held, and the cycle in which the next word is accepted.

// File: rtl/lcd_pixel_unpack.sv
module lcd_pixel_unpack #(
  parameter int WORD_W    = 64,
  parameter int PAL_WORDS = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   bpp_sel,
  input  logic [1:0]                   order_sel,
  input  logic [WORD_W-1:0]            in_data,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         pal_we,
  input  logic [$clog2(PAL_WORDS)-1:0] pal_addr,
  input  logic [31:0]                  pal_wdata,
  output logic [23:0]                  pix_data,
  output logic                         pix_valid,
  input  logic                         pix_ready
);
  localparam int PAL_AW = $clog2(PAL_WORDS);
  localparam int IDX_W  = $clog2(WORD_W);

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              full_q;
  logic [31:0]       pal_mem [PAL_WORDS];

  logic [2:0]        lg;
  logic [IDX_W-1:0]  last_idx;
  logic [23:0]       raw;
  logic [31:0]       pal_word;
  logic [15:0]       entry;
  logic              last, pop, take;

  assign lg       = (bpp_sel > 3'd5) ? 3'd5 : bpp_sel;
  assign last_idx = IDX_W'((WORD_W >> lg) - 1);
  assign last     = (cnt_q == last_idx);
  assign in_ready = !full_q || (pix_ready && last);
  assign pop      = in_valid && in_ready;
  assign take     = full_q && pix_ready;
  assign pix_valid = full_q;

  always_comb begin
    int w;
    int k;
    int pos;
    w = 1 << lg;
    k = int'(cnt_q);
    if (order_sel == 2'd1)
      pos = WORD_W - (k + 1) * w;
    else if (order_sel == 2'd2 && lg < 3'd3)
      pos = ((k >> (3 - int'(lg))) << 3) + 8 - (((k & ((8 >> lg) - 1)) + 1) * w);
    else
      pos = k * w;
    raw = 24'((word_q >> pos) & ((WORD_W'(1) << w) - WORD_W'(1)));
  end

  assign pal_word = pal_mem[raw[PAL_AW:1]];
  assign entry    = raw[0] ? pal_word[31:16] : pal_word[15:0];
  assign pix_data = (lg < 3'd4)  ? {8'h00, entry} :
                    (lg == 3'd4) ? {8'h00, raw[15:0]} : raw;

  always_ff @(posedge clk)
    if (pal_we) pal_mem[pal_addr] <= pal_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else if (pop) begin
      word_q <= in_data;
      cnt_q  <= '0;
      full_q <= 1'b1;
    end else if (take) begin
      if (last) full_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_pixel_unpack_chk.sv
module lcd_pixel_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bpp_sel,
  input logic [1:0]  order_sel,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pal_we,
  input logic [23:0] pix_data,
  input logic        pix_valid,
  input logic        pix_ready
);
  // R10
  stall_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> pix_valid);

  // R10
  stall_keeps_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready && !pal_we) |=>
      ($stable(pix_data) || !$stable(bpp_sel) || !$stable(order_sel)));

  // R10
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |-> !in_ready);

  // R11
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> in_ready);

  // R11
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> pix_valid);

  // R2 R4
  upper_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && bpp_sel < 3'd5) |-> (pix_data[23:16] == 8'h00));
endmodule

bind lcd_pixel_unpack lcd_pixel_unpack_chk u_chk (.*);

// File: tb/lcd_pixel_unpack_bench.sv
`timescale 1ns/1ps
module lcd_pixel_unpack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bpp_sel = 3'd3;
  logic [1:0]  order_sel = 2'd0;
  logic [63:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        pal_we = 1'b0;
  logic [6:0]  pal_addr = '0;
  logic [31:0] pal_wdata = '0;
  logic [23:0] pix_data;
  logic        pix_valid;
  logic        pix_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [15:0] pm [256];

  always #5 clk = ~clk;

  lcd_pixel_unpack u_lcd_pixel_unpack (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int width_of(logic [2:0] b);
    return (b >= 3'd5) ? 32 : (1 << b);
  endfunction

  function automatic logic [23:0] expect_pix(logic [63:0] d, logic [2:0] b, logic [1:0] o, int k);
    int w;
    int pos;
    int per;
    logic [63:0] v;
    w = width_of(b);
    per = 8 / w;
    if (o == 2'd1) pos = 64 - (k + 1) * w;
    else if (o == 2'd2 && w < 8) pos = (k / per) * 8 + (8 - w * ((k % per) + 1));
    else pos = k * w;
    v = (d >> pos) & ((64'd1 << w) - 64'd1);
    if (w <= 8) return {8'h00, pm[v[7:0]]};
    if (w == 16) return {8'h00, v[15:0]};
    return v[23:0];
  endfunction

  task automatic pal_write(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    pal_we = 1'b1; pal_addr = a; pal_wdata = d;
    @(negedge clk);
    pal_we = 1'b0;
    pm[{a, 1'b0}] = d[15:0];
    pm[{a, 1'b1}] = d[31:16];
  endtask

  task automatic load_word(logic [63:0] d, string req);
    @(negedge clk);
    in_data = d; in_valid = 1'b1; pix_ready = 1'b0;
    check({req, " R11 ready when empty"}, 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R11 valid after accept"}, 64'(pix_valid), 64'd1);
  endtask

  task automatic drain(logic [63:0] d, int first, string req);
    int n;
    n = 64 / width_of(bpp_sel);
    for (int k = first; k < n; k++) begin
      check(req, 64'(pix_data), 64'(expect_pix(d, bpp_sel, order_sel, k)));
      pix_ready = 1'b1;
      check({req, " R9 ready only on last"}, 64'(in_ready), 64'(k == n - 1));
      @(negedge clk);
    end
    pix_ready = 1'b0;
    check({req, " R9 empty after last"}, 64'(pix_valid), 64'd0);
  endtask

  task automatic run_word(logic [2:0] b, logic [1:0] o, logic [63:0] d, string req);
    bpp_sel = b; order_sel = o;
    load_word(d, req);
    drain(d, 0, req);
  endtask

  task automatic test_reset();
    check("R1 pix_valid in reset", 64'(pix_valid), 64'd0);
    check("R1 in_ready in reset", 64'(in_ready), 64'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 pix_valid after release", 64'(pix_valid), 64'd0);
    check("R1 in_ready after release", 64'(in_ready), 64'd1);
  endtask

  task automatic test_palette_load();
    for (int a = 0; a < 128; a++) begin
      logic [7:0] e0, e1;
      e0 = 8'(2 * a); e1 = 8'(2 * a + 1);
      pal_write(7'(a), {e1 ^ 8'h5A, ~e1, e0 ^ 8'h5A, ~e0});
    end
  endtask

  task automatic test_palettized();
    run_word(3'd3, 2'd0, 64'h0706050403020100, "R2 R6 8bpp little");
    run_word(3'd3, 2'd1, 64'h0706050403020100, "R2 R7 8bpp big");
    run_word(3'd2, 2'd2, 64'hFEDCBA9876543210, "R2 R8 4bpp mixed");
    run_word(3'd1, 2'd2, 64'h1B2D3E4F5A697887, "R2 R8 2bpp mixed");
    run_word(3'd0, 2'd2, 64'h8001_C003_A5F0_0F5A, "R2 R8 1bpp mixed");
    run_word(3'd0, 2'd0, 64'h8001_C003_A5F0_0F5A, "R2 R6 1bpp little");
    run_word(3'd1, 2'd1, 64'h1B2D3E4F5A697887, "R2 R7 2bpp big");
    run_word(3'd3, 2'd2, 64'h8899AABBCCDDEEFF, "R2 R8 8bpp mixed as little");
    run_word(3'd2, 2'd3, 64'h0123456789ABCDEF, "R2 R6 4bpp code3 little");
  endtask

  task automatic test_true_colour();
    run_word(3'd4, 2'd0, 64'h4444_3333_2222_1111, "R4 R6 16bpp little");
    run_word(3'd4, 2'd1, 64'h4444_3333_2222_1111, "R4 R7 16bpp big");
    run_word(3'd5, 2'd0, 64'hAA123456_BB654321, "R5 R6 24bpp little");
    run_word(3'd5, 2'd1, 64'hAA123456_BB654321, "R5 R7 24bpp big");
    run_word(3'd7, 2'd0, 64'hFF0A0B0C_EE0D0E0F, "R5 code7 24bpp");
  endtask

  task automatic test_backpressure();
    logic [23:0] held;
    bpp_sel = 3'd4; order_sel = 2'd0;
    load_word(64'h0004_0003_0002_0001, "R10");
    held = pix_data;
    in_data = 64'hDEAD_BEEF_0000_0000; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 held pixel", 64'(pix_data), 64'(held));
      check("R10 held valid", 64'(pix_valid), 64'd1);
      check("R10 no intake", 64'(in_ready), 64'd0);
    end
    in_valid = 1'b0;
    drain(64'h0004_0003_0002_0001, 0, "R10 after stall");
  endtask

  task automatic test_back_to_back();
    bpp_sel = 3'd5; order_sel = 2'd0;
    load_word(64'h00AAAAAA_00BBBBBB, "R9 b2b");
    check("R9 first slot", 64'(pix_data), 64'hBBBBBB);
    pix_ready = 1'b1;
    @(negedge clk);
    in_data = 64'h00CCCCCC_00DDDDDD; in_valid = 1'b1;
    check("R9 ready on last pixel", 64'(in_ready), 64'd1);
    check("R9 second slot", 64'(pix_data), 64'hAAAAAA);
    @(negedge clk);
    in_valid = 1'b0; pix_ready = 1'b0;
    check("R9 next word valid at once", 64'(pix_valid), 64'd1);
    drain(64'h00CCCCCC_00DDDDDD, 0, "R9 second word");
  endtask

  task automatic test_palette_rewrite();
    bpp_sel = 3'd3; order_sel = 2'd0;
    load_word(64'h0000_0000_0000_0706, "R3");
    check("R3 before rewrite", 64'(pix_data), 64'({8'h00, pm[6]}));
    pal_write(7'd3, 32'hBEEF_CAFE);
    check("R3 even entry after rewrite", 64'(pix_data), 64'h00CAFE);
    pix_ready = 1'b1;
    @(negedge clk);
    pix_ready = 1'b0;
    check("R3 odd entry after rewrite", 64'(pix_data), 64'h00BEEF);
    drain(64'h0000_0000_0000_0706, 1, "R3 drain");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_palette_load();
    test_palettized();
    test_true_colour();
    test_backpressure();
    test_back_to_back();
    test_palette_rewrite();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule